// File: doc/BRIEF.md
# Burst-Resistant Packet Protocol Encoder

This block turns one 128-bit message into a serial bit stream that can survive short, strong interference bursts. A start pulse captures the message and two mode flags. The stream then alternates a long synchronization run of alternating bits with a data packet. The data packet carries the 16 message bytes, and each byte is wrapped with its own index and two parity bits. Because every word names its own position and every packet is repeated, a receiver can rebuild the message from the pieces that got through.

The encoder advances one bit for each pulse on its bit-rate tick input. Two repetition modes are available. In single mode the block sends a fixed number of sync/data pairs and then stops on its own. In continuous mode it keeps repeating until a stop request arrives. An optional duty-gating mode switches the transmit enable off for the second half of every observation window. While the enable is off the bit position is held, so no bit is skipped. The outputs are the current bit, a transmit enable for the RF path, and a done flag.

Top module: `burst_pkt_encoder`

## Requirements
- R1: After reset, tx_en, done and tx_bit are all 0.
- R2: A start pulse while idle captures msg, cont_mode and duty_en. From the next cycle the block is transmitting: tx_en=1, done=0, and the first bit is 0. A start pulse while transmitting is ignored, and so is any change on msg.
- R3: Each pair opens with a sync packet of SYNC_LEN (252) bits that alternate 0,1,0,1 and begin with 0.
- R4: The sync packet is followed by a data packet of 16 words, 14 bits each (224 bits). Word k is built from byte msg[8k+7:8k], and the words go out in order k=0..15. Each word is sent MSB first as: the 8 data bits (bit 7 first), the 4-bit index k (MSB first), the XOR of the data byte, and then the XOR of the index. The last two are even-parity bits.
- R5: The stream moves forward exactly one bit on each clock where bit_tick=1 and tx_en=1. On any other clock tx_bit holds its value.
- R6: In single mode (cont_mode=0), exactly PAIRS (4) sync/data pairs are sent. In the cycle after the last bit is consumed, tx_en=0 and done=1.
- R7: In single mode, stop_req is ignored: transmission continues and the full bit sequence completes.
- R8: In continuous mode (cont_mode=1), pairs repeat with no limit. A stop_req while transmitting gives tx_en=0 and done=1 in the next cycle.
- R9: With duty gating on, the clocks are grouped into windows of WINDOW_CLKS, counted from the first transmitting cycle. tx_en is 1 for the first WINDOW_CLKS/2 clocks of each window and 0 for the rest. Ticks in the off half are not consumed, and the stream resumes from the held bit.
- R10: done stays 1 until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transmission (accepted when idle) |
| msg | input | 128 | Message; byte k sits at bits 8k+7..8k |
| cont_mode | input | 1 | 0 = single mode, 1 = continuous mode |
| duty_en | input | 1 | Enable 50% duty gating |
| stop_req | input | 1 | Stop request (acted on in continuous mode only) |
| bit_tick | input | 1 | Bit-rate strobe, one bit per pulse |
| tx_bit | output | 1 | Current serial bit |
| tx_en | output | 1 | Transmit enable for the RF path |
| done | output | 1 | Transmission finished |

## Verification
The word builder is tested with several message patterns, each chosen to expose a different class of fault:
- All-zero and all-one bytes separate the data parity bit from the index parity bit.
- An incrementing byte pattern shows whether bytes are taken in order and whether the data and index fields are swapped.
- A mixed pattern checks bit order inside each byte.

The tick is pulsed every cycle, every second cycle and every third cycle, which separates true per-tick stepping from free-running. Continuous mode is run beyond four pairs to show it is not capped. Duty gating is checked both by the exact number of cycles a full message takes and by the bit stream itself, which tells a held position apart from skipped bits.

// File: rtl/burst_pkt_encoder.sv
module burst_pkt_encoder #(
  parameter int SYNC_LEN    = 252,
  parameter int WORDS       = 16,
  parameter int PAIRS       = 4,
  parameter int WINDOW_CLKS = 2_500_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [WORDS*8-1:0]   msg,
  input  logic                 cont_mode,
  input  logic                 duty_en,
  input  logic                 stop_req,
  input  logic                 bit_tick,
  output logic                 tx_bit,
  output logic                 tx_en,
  output logic                 done
);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int WORD_W = 8 + IDX_W + 2;
  localparam int BP_W   = $clog2(WORD_W);
  localparam int SC_W   = $clog2(SYNC_LEN);
  localparam int RP_W   = $clog2(PAIRS) + 1;
  localparam int WIN_W  = $clog2(WINDOW_CLKS);
  localparam int HALF   = WINDOW_CLKS / 2;

  logic [WORDS*8-1:0] msg_q;
  logic               cont_q, duty_q, active, in_data, done_q;
  logic [SC_W-1:0]    sync_cnt;
  logic [IDX_W-1:0]   word_idx;
  logic [BP_W-1:0]    bit_pos;
  logic [RP_W-1:0]    reps;
  logic [WIN_W-1:0]   win_cnt;

  logic [7:0]         cur_byte;
  logic [WORD_W-1:0]  word;
  logic               gate_open, step, sync_last, word_last, pkt_last, last_step, stop_now;

  assign cur_byte  = msg_q[{word_idx, 3'b000} +: 8];
  assign word      = {cur_byte, word_idx, ^cur_byte, ^word_idx};
  assign gate_open = !duty_q || (win_cnt < WIN_W'(HALF));
  assign step      = active && gate_open && bit_tick;
  assign sync_last = sync_cnt == SC_W'(SYNC_LEN - 1);
  assign word_last = bit_pos == BP_W'(WORD_W - 1);
  assign pkt_last  = word_last && (word_idx == IDX_W'(WORDS - 1));
  assign last_step = step && in_data && pkt_last && !cont_q && (reps == RP_W'(PAIRS - 1));
  assign stop_now  = active && cont_q && stop_req;

  assign tx_en  = active && gate_open;
  assign done   = done_q;
  assign tx_bit = active && (in_data ? word[BP_W'(WORD_W - 1) - bit_pos] : sync_cnt[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_q    <= '0;
      cont_q   <= 1'b0;
      duty_q   <= 1'b0;
      active   <= 1'b0;
      in_data  <= 1'b0;
      done_q   <= 1'b0;
      sync_cnt <= '0;
      word_idx <= '0;
      bit_pos  <= '0;
      reps     <= '0;
      win_cnt  <= '0;
    end else if (!active) begin
      if (start) begin
        msg_q    <= msg;
        cont_q   <= cont_mode;
        duty_q   <= duty_en;
        active   <= 1'b1;
        in_data  <= 1'b0;
        done_q   <= 1'b0;
        sync_cnt <= '0;
        word_idx <= '0;
        bit_pos  <= '0;
        reps     <= '0;
        win_cnt  <= '0;
      end
    end else begin
      win_cnt <= (win_cnt == WIN_W'(WINDOW_CLKS - 1)) ? '0 : win_cnt + 1'b1;
      if (stop_now) begin
        active <= 1'b0;
        done_q <= 1'b1;
      end else if (step) begin
        if (!in_data) begin
          if (sync_last) begin
            in_data  <= 1'b1;
            sync_cnt <= '0;
          end else begin
            sync_cnt <= sync_cnt + 1'b1;
          end
        end else if (!word_last) begin
          bit_pos <= bit_pos + 1'b1;
        end else begin
          bit_pos <= '0;
          if (!pkt_last) begin
            word_idx <= word_idx + 1'b1;
          end else begin
            word_idx <= '0;
            in_data  <= 1'b0;
            if (last_step) begin
              active <= 1'b0;
              done_q <= 1'b1;
            end else if (!cont_q) begin
              reps <= reps + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/burst_pkt_encoder_chk.sv
module burst_pkt_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic stop_req,
  input logic bit_tick,
  input logic tx_bit,
  input logic tx_en,
  input logic done,
  input logic active,
  input logic cont_q,
  input logic last_step
);
  assert_start_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !active |=> active && tx_en && !done && !tx_bit);

  assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active && !bit_tick && !(cont_q && stop_req) |=> $stable(tx_bit));

  assert_stop_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active && !cont_q && stop_req && !last_step |=> active);

  assert_stop_cont_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active && cont_q && stop_req |=> !tx_en && done);

  assert_gate_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active && !tx_en && !(cont_q && stop_req) |=> $stable(tx_bit));

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_en && !active);
endmodule

bind burst_pkt_encoder burst_pkt_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop_req(stop_req), .bit_tick(bit_tick),
  .tx_bit(tx_bit), .tx_en(tx_en), .done(done), .active(active), .cont_q(cont_q),
  .last_step(last_step)
);

// File: tb/burst_pkt_encoder_tb.sv
module burst_pkt_encoder_tb;
  localparam int WIN  = 40;
  localparam int PAIR = 476;
  localparam int WD   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, cont_in = 1'b0, duty_in = 1'b0, stop_req = 1'b0, bit_tick = 1'b0;
  logic [127:0] msg_in = '0;
  logic tx_bit, tx_en, done;
  int   n_run = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  burst_pkt_encoder #(.WINDOW_CLKS(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .msg(msg_in), .cont_mode(cont_in),
    .duty_en(duty_in), .stop_req(stop_req), .bit_tick(bit_tick),
    .tx_bit(tx_bit), .tx_en(tx_en), .done(done)
  );

  localparam logic [127:0] VEC_MSG [4] = '{
    128'h0,
    {128{1'b1}},
    128'h0F0E0D0C0B0A09080706050403020100,
    128'hA5C31E7869F0D2B4_3C5A96E1087F4B2D
  };
  localparam int VEC_PER [4] = '{1, 2, 3, 1};

  task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [127:0] m, input int p);
    int q, w, b;
    logic [7:0]  by;
    logic [3:0]  ix;
    logic [13:0] wd;
    if (p < 252) return logic'(p % 2);
    q  = p - 252;
    w  = q / 14;
    b  = q % 14;
    by = m[w*8 +: 8];
    ix = 4'(w);
    wd = {by, ix, ^by, ^ix};
    return wd[13 - b];
  endfunction

  task automatic do_start(input logic [127:0] m, input logic cont, input logic duty);
    @(negedge clk);
    msg_in = m; cont_in = cont; duty_in = duty; start = 1'b1; bit_tick = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic stream(input logic [127:0] m, input int npairs, input int per,
                        input int inj_start_c, input int inj_stop_c,
                        output int cycles, output logic en19, output logic en20);
    int k = 0, c = 0, errs = 0, fa = 0, fe = 0;
    logic stop_pending = 1'b0;
    en19 = 1'b0; en20 = 1'b0;
    while (k < npairs * PAIR && c < 40000) begin
      start    = (c == inj_start_c);
      msg_in   = (c == inj_start_c) ? ~m : m;
      if (stop_pending) begin
        chk(tx_en == 1'b1, "R7", "tx_en after ignored stop", int'(tx_en), 1);
        stop_pending = 1'b0;
      end
      stop_req = (c == inj_stop_c);
      if (c == inj_stop_c) stop_pending = 1'b1;
      bit_tick = ((c % per) == 0);
      if (c == 19) en19 = tx_en;
      if (c == 20) en20 = tx_en;
      if (tx_en && bit_tick) begin
        if (tx_bit !== exp_bit(m, k % PAIR)) begin
          if (errs == 0) begin fa = int'(tx_bit); fe = int'(exp_bit(m, k % PAIR)); end
          errs++;
        end
        k++;
        if (k % PAIR == 252) begin
          chk(errs == 0, "R3", "sync packet bit", fa, fe); errs = 0;
        end else if (k % PAIR == 0) begin
          chk(errs == 0, "R4", "data packet bit", fa, fe); errs = 0;
        end
      end
      c++;
      @(negedge clk);
      start = 1'b0; stop_req = 1'b0; msg_in = m;
    end
    cycles = c;
  endtask

  initial begin
    int cy;
    logic e19, e20;
    repeat (3) @(negedge clk);
    chk(tx_en == 1'b0, "R1", "tx_en in reset", int'(tx_en), 0);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    chk(tx_bit == 1'b0, "R1", "tx_bit in reset", int'(tx_bit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_en == 1'b0 && done == 1'b0, "R1", "idle after reset", int'(tx_en), 0);

    for (int v = 0; v < 4; v++) begin
      do_start(VEC_MSG[v], 1'b0, 1'b0);
      chk(tx_en == 1'b1 && tx_bit == 1'b0, "R2", "first bit after start", int'(tx_bit), 0);
      chk(done == 1'b0, "R10", "done cleared by start", int'(done), 0);
      // R5 tick periods 1,2,3 ; R2 start ignored in v=1 ; R7 stop ignored in v=2
      stream(VEC_MSG[v], 4, VEC_PER[v], (v == 1) ? 100 : -1, (v == 2) ? 300 : -1, cy, e19, e20);
      chk(tx_en == 1'b0, "R6", "tx_en after four pairs", int'(tx_en), 0);
      chk(done == 1'b1, "R6", "done after four pairs", int'(done), 1);
      repeat (5) @(negedge clk);
      chk(done == 1'b1 && tx_en == 1'b0, "R10", "done held while idle", int'(done), 1);
    end

    do_start(VEC_MSG[2], 1'b1, 1'b0);
    stream(VEC_MSG[2], 5, 1, -1, -1, cy, e19, e20);
    chk(tx_en == 1'b1 && done == 1'b0, "R8", "continuous runs past four pairs", int'(tx_en), 1);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk(tx_en == 1'b0, "R8", "tx_en after stop", int'(tx_en), 0);
    chk(done == 1'b1, "R8", "done after stop", int'(done), 1);
    repeat (4) @(negedge clk);
    chk(done == 1'b1, "R10", "done held after stop", int'(done), 1);

    do_start(VEC_MSG[3], 1'b0, 1'b1);
    chk(done == 1'b0 && tx_en == 1'b1, "R10", "restart clears done", int'(done), 0);
    stream(VEC_MSG[3], 4, 1, -1, -1, cy, e19, e20);
    chk(e19 == 1'b1, "R9", "tx_en at end of on half", int'(e19), 1);
    chk(e20 == 1'b0, "R9", "tx_en in off half", int'(e20), 0);
    chk(cy == 3804, "R9", "cycles for gated message", cy, 3804);
    chk(done == 1'b1 && tx_en == 1'b0, "R6", "gated single message ends", int'(done), 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    while (cyc < WD) begin
      @(posedge clk);
      cyc++;
    end
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, WD);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule